// File: doc/BRIEF.md
# Cursor Generator Host Access Port

This block is the host side of a video cursor generator. It holds one internal 16-bit address pointer, a file of thirteen byte-wide control registers and a 512-word cursor pattern RAM. The host sees four word locations, selected by a 2-bit location code. Two locations load the pointer one byte at a time. The other two are data windows that use the pointer: a byte window onto the control registers and a 16-bit window onto the pattern RAM. Every access through either data window moves the pointer forward by one. A host can therefore stream a whole table or the pattern after a single pointer load.

Byte values travel on both lanes of the 16-bit bus. On a write the block takes the low lane. On a read it returns the byte on both lanes. Reads are registered: data and `rvalid` appear one cycle after the read strobe. A small access state machine sets that timing. It has two states. `ST_IDLE` means no read response is pending. `ST_RESP` means a response is presented this cycle. The transition `TR_ISSUE` (read strobe in either state) enters or stays in `ST_RESP`. The transition `TR_DONE` (no read strobe) returns to `ST_IDLE`.

Top module: `cursor_host_port`

## Requirements
- R1: After reset the pointer is 0x0000, all thirteen control registers read as zero, `rvalid` is 0 and `rdata` is 0.
- R2: A write to location code 0 loads pointer bits 7:0 from `wdata[7:0]`. A write to location code 1 loads pointer bits 15:8 from `wdata[7:0]`. Each load leaves the other byte unchanged, and neither load advances the pointer.
- R3: Every read or write at location code 2 (pattern window) or code 3 (register window) advances the pointer by one after the access. The pointer wraps from 0xFFFF to 0x0000.
- R4: A register-window write stores `wdata[7:0]` at the register indexed by the pointer (indices 0 to 12). A register-window read returns that byte on both lanes, `{b, b}`.
- R5: Registers 2 and 4 (cursor X and Y high bytes) keep only their low 4 bits, so a read returns zero in bits 7:4 of the byte.
- R6: A register-window write with pointer above 12 changes no register. A register-window read there returns 0x0000.
- R7: A pattern-window write with pointer in 0x000 to 0x1FF stores the full 16-bit `wdata` at that word. A later pattern-window read of the word returns it.
- R8: A pattern-window write with pointer at or above 0x200 changes no word. A pattern-window read there returns 0x0000.
- R9: `rvalid` is 1 exactly in the cycle after a read strobe, and `rdata` is valid in that cycle. Back-to-back read strobes give back-to-back responses. `rdata` is 0 whenever `rvalid` is 0.
- R10: A read at location code 0 or 1 returns the pointer's low or high byte on both lanes and does not advance the pointer.
- R11: When `wr_en` and `rd_en` are high in the same cycle, the access is a write only: no read response follows, and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc | input | 2 | Location code: 0 pointer low, 1 pointer high, 2 pattern window, 3 register window |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 16 | Write data; bytes on the low lane |
| rdata | output | 16 | Read data, valid when `rvalid` is high |
| rvalid | output | 1 | Read response valid, one cycle after `rd_en` |

## Verification
The bench builds the block with its default parameters: a 16-bit pointer, thirteen registers and 512 pattern words. This puts the pointer wrap at 0xFFFF and the pattern upper boundary at 0x1FF/0x200 within a few accesses of a pointer load. Streams across registers 0 to 4 and 12 to 13 exercise the narrow high-byte registers and the out-of-range index. Reads at the pointer locations show the post-increment pointer value through the normal port.

// File: rtl/cursor_port_pkg.sv
package cursor_port_pkg;

    typedef enum logic [1:0] {
        LOC_PTR_LO = 2'd0,
        LOC_PTR_HI = 2'd1,
        LOC_MAP    = 2'd2,
        LOC_REG    = 2'd3
    } loc_e;

    typedef enum logic {
        SRC_BYTE = 1'b0,
        SRC_MAP  = 1'b1
    } rsrc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } port_st_e;

endpackage

// File: rtl/cp_pointer.sv
module cp_pointer #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              bump,
    input  logic [7:0]        din,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - 8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load_lo) begin
            ptr[7:0] <= din;
        end else if (load_hi) begin
            ptr[ADDR_W-1:8] <= HI_W'(din);
        end else if (bump) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R2: low-byte load replaces only the low byte
    assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> (ptr[7:0] == $past(din)) && (ptr[ADDR_W-1:8] == $past(ptr[ADDR_W-1:8])));

    // R2: high-byte load leaves the low byte alone
    assert_hi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_hi && !load_lo) |=> (ptr[7:0] == $past(ptr[7:0])));

    // R3: a data access moves the pointer by exactly one, with wrap
    assert_bump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !load_lo && !load_hi) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/cp_regfile.sv
module cp_regfile #(
    parameter int NUM_REGS = 13,
    parameter int IDX_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wbyte,
    output logic [7:0]       rbyte
);
    localparam int SEL_W = $clog2(NUM_REGS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    logic [NUM_REGS-1:0][7:0] regs;
    logic                     in_range;

    assign in_range = (idx <= LAST_IDX);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // cursor position high bytes keep a nibble only
        localparam logic [7:0] KEEP = ((i == 2) || (i == 4)) ? 8'h0F : 8'hFF;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && in_range && (idx[SEL_W-1:0] == SEL_W'(i))) begin
                regs[i] <= wbyte & KEEP;
            end
        end
    end

    always_comb begin
        rbyte = 8'h00;
        if (in_range) begin
            rbyte = regs[idx[SEL_W-1:0]];
        end
    end

    // R6: a write beyond the last index disturbs no register
    assert_oob_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !in_range) |=> $stable(regs));

endmodule

// File: rtl/cp_pattern_ram.sv
module cp_pattern_ram #(
    parameter int WORDS = 512,
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      wword,
    output logic [15:0]      rword
);
    localparam int AW = $clog2(WORDS);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(WORDS - 1);

    logic [15:0] mem [WORDS];
    logic        in_range;

    assign in_range = (idx <= LAST_WORD);

    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[idx[AW-1:0]] <= wword;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rword <= '0;
        end else if (re) begin
            rword <= in_range ? mem[idx[AW-1:0]] : 16'h0000;
        end
    end

    // R8: an out-of-range read yields zero
    assert_oob_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (re && !in_range) |=> (rword == 16'h0000));

endmodule

// File: rtl/cursor_host_port.sv
module cursor_host_port
    import cursor_port_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_REGS  = 13,
    parameter int MAP_WORDS = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  loc,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        rvalid
);
    loc_e              loc_s;
    logic              is_wr;
    logic              is_rd;
    logic              data_acc;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        reg_byte;
    logic [15:0]       map_word;
    port_st_e          state;
    port_st_e          state_nx;
    rsrc_e             src_q;
    logic [7:0]        byte_q;

    assign loc_s    = loc_e'(loc);
    assign is_wr    = wr_en;
    assign is_rd    = rd_en && !wr_en;
    assign data_acc = (is_wr || is_rd) && ((loc_s == LOC_MAP) || (loc_s == LOC_REG));

    cp_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (is_wr && (loc_s == LOC_PTR_LO)),
        .load_hi (is_wr && (loc_s == LOC_PTR_HI)),
        .bump    (data_acc),
        .din     (wdata[7:0]),
        .ptr     (ptr)
    );

    cp_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (is_wr && (loc_s == LOC_REG)),
        .idx   (ptr),
        .wbyte (wdata[7:0]),
        .rbyte (reg_byte)
    );

    cp_pattern_ram #(.WORDS(MAP_WORDS), .IDX_W(ADDR_W)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (is_wr && (loc_s == LOC_MAP)),
        .re    (is_rd && (loc_s == LOC_MAP)),
        .idx   (ptr),
        .wword (wdata),
        .rword (map_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: TR_ISSUE on a read strobe, TR_DONE otherwise
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = is_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = is_rd ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // capture of the byte-wide read sources at the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_BYTE;
            byte_q <= '0;
        end else if (is_rd) begin
            unique case (loc_s)
                LOC_PTR_LO: begin src_q <= SRC_BYTE; byte_q <= ptr[7:0];        end
                LOC_PTR_HI: begin src_q <= SRC_BYTE; byte_q <= ptr[ADDR_W-1:8]; end
                LOC_MAP:    begin src_q <= SRC_MAP;  byte_q <= byte_q;          end
                LOC_REG:    begin src_q <= SRC_BYTE; byte_q <= reg_byte;        end
                default:    begin src_q <= SRC_BYTE; byte_q <= byte_q;          end
            endcase
        end
    end

    // outputs
    always_comb begin
        rvalid = 1'b0;
        rdata  = 16'h0000;
        unique case (state)
            ST_IDLE: begin
                rvalid = 1'b0;
                rdata  = 16'h0000;
            end
            ST_RESP: begin
                rvalid = 1'b1;
                rdata  = (src_q == SRC_MAP) ? map_word : {byte_q, byte_q};
            end
            default: begin
                rvalid = 1'b0;
                rdata  = 16'h0000;
            end
        endcase
    end

    // R9: a read strobe is answered in the next cycle
    assert_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rvalid);

    // R9: no strobe, no response, and quiet data
    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rvalid && (rdata == 16'h0000)));

    // R11: simultaneous strobes give no read response
    assert_wr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> !rvalid);

    // R10: pointer low byte read shows the pointer before any later change
    assert_ptr_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && (loc == 2'd0)) |=> (rdata == {2{$past(ptr[7:0])}}));

endmodule

// File: tb/tb_cursor_host_port.sv
module tb_cursor_host_port;

    typedef struct packed {
        logic [1:0]  loc;
        logic        wr;
        logic        rd;
        logic [15:0] wd;
        logic [15:0] ex;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 41;

    // loc codes: 0 ptr low, 1 ptr high, 2 pattern window, 3 register window
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 1'b0, 16'h0000, 16'h0000, 8'd2},   // 0  ptr low = 00
        '{2'd1, 1'b1, 1'b0, 16'h0000, 16'h0000, 8'd2},   // 1  ptr high = 00
        '{2'd3, 1'b1, 1'b0, 16'h4141, 16'h0000, 8'd4},   // 2  reg0 = 41 (R4)
        '{2'd3, 1'b1, 1'b0, 16'h3434, 16'h0000, 8'd4},   // 3  reg1 = 34
        '{2'd3, 1'b1, 1'b0, 16'hABAB, 16'h0000, 8'd5},   // 4  reg2 keeps 0B (R5)
        '{2'd3, 1'b1, 1'b0, 16'h7777, 16'h0000, 8'd4},   // 5  reg3 = 77
        '{2'd3, 1'b1, 1'b0, 16'hFEFE, 16'h0000, 8'd5},   // 6  reg4 keeps 0E
        '{2'd0, 1'b1, 1'b0, 16'h0000, 16'h0000, 8'd2},   // 7  ptr back to 0
        '{2'd3, 1'b0, 1'b1, 16'h0000, 16'h4141, 8'd4},   // 8
        '{2'd3, 1'b0, 1'b1, 16'h0000, 16'h3434, 8'd4},   // 9
        '{2'd3, 1'b0, 1'b1, 16'h0000, 16'h0B0B, 8'd5},   // 10
        '{2'd3, 1'b0, 1'b1, 16'h0000, 16'h7777, 8'd4},   // 11
        '{2'd3, 1'b0, 1'b1, 16'h0000, 16'h0E0E, 8'd5},   // 12
        '{2'd0, 1'b0, 1'b1, 16'h0000, 16'h0505, 8'd10},  // 13 ptr low = 5 (R10)
        '{2'd0, 1'b1, 1'b0, 16'h0C0C, 16'h0000, 8'd2},   // 14 ptr = 12
        '{2'd3, 1'b1, 1'b0, 16'h5A5A, 16'h0000, 8'd4},   // 15 reg12 = 5A
        '{2'd3, 1'b1, 1'b0, 16'h9999, 16'h0000, 8'd6},   // 16 idx13 ignored (R6)
        '{2'd0, 1'b1, 1'b0, 16'h0C0C, 16'h0000, 8'd2},   // 17 ptr = 12
        '{2'd3, 1'b0, 1'b1, 16'h0000, 16'h5A5A, 8'd4},   // 18
        '{2'd3, 1'b0, 1'b1, 16'h0000, 16'h0000, 8'd6},   // 19 idx13 reads zero
        '{2'd0, 1'b0, 1'b1, 16'h0000, 16'h0E0E, 8'd3},   // 20 ptr now 14 (R3)
        '{2'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 8'd2},   // 21 ptr low = FF
        '{2'd1, 1'b1, 1'b0, 16'h0101, 16'h0000, 8'd2},   // 22 ptr = 01FF
        '{2'd2, 1'b1, 1'b0, 16'hBEEF, 16'h0000, 8'd7},   // 23 word 1FF (R7)
        '{2'd2, 1'b1, 1'b0, 16'h1234, 16'h0000, 8'd8},   // 24 word 200 ignored (R8)
        '{2'd0, 1'b1, 1'b0, 16'hFEFE, 16'h0000, 8'd2},   // 25 ptr = 02FE
        '{2'd1, 1'b1, 1'b0, 16'h0101, 16'h0000, 8'd2},   // 26 ptr = 01FE
        '{2'd2, 1'b1, 1'b0, 16'hC0DE, 16'h0000, 8'd7},   // 27 word 1FE
        '{2'd0, 1'b1, 1'b0, 16'hFEFE, 16'h0000, 8'd2},   // 28 ptr = 01FE
        '{2'd2, 1'b0, 1'b1, 16'h0000, 16'hC0DE, 8'd7},   // 29
        '{2'd2, 1'b0, 1'b1, 16'h0000, 16'hBEEF, 8'd7},   // 30
        '{2'd2, 1'b0, 1'b1, 16'h0000, 16'h0000, 8'd8},   // 31 word 200 reads zero
        '{2'd1, 1'b0, 1'b1, 16'h0000, 16'h0202, 8'd10},  // 32 ptr high = 02
        '{2'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 8'd2},   // 33
        '{2'd1, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 8'd2},   // 34 ptr = FFFF
        '{2'd2, 1'b0, 1'b1, 16'h0000, 16'h0000, 8'd8},   // 35 read wraps ptr
        '{2'd0, 1'b0, 1'b1, 16'h0000, 16'h0000, 8'd3},   // 36 low = 00 (wrap)
        '{2'd1, 1'b0, 1'b1, 16'h0000, 16'h0000, 8'd3},   // 37 high = 00 (wrap)
        '{2'd2, 1'b1, 1'b0, 16'h00FF, 16'h0000, 8'd7},   // 38 word 0
        '{2'd0, 1'b1, 1'b0, 16'h0000, 16'h0000, 8'd2},   // 39 ptr = 0
        '{2'd2, 1'b0, 1'b1, 16'h0000, 16'h00FF, 8'd7}    // 40
    };

    logic        clk;
    logic        rst_n;
    logic [1:0]  loc;
    logic        wr_en;
    logic        rd_en;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        rvalid;

    int n_chk  = 0;
    int n_fail = 0;

    cursor_host_port dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .loc    (loc),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wdata  (wdata),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access, then idle; a read is checked one cycle after its strobe
    task automatic access(input logic [1:0] l, input logic w, input logic r,
                          input logic [15:0] d, input logic [15:0] e, input string req);
        @(negedge clk);
        loc = l; wr_en = w; rd_en = r; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (r && !w) check(req, {rvalid, rdata}, {1'b1, e});
    endtask

    initial begin
        rst_n = 1'b0; loc = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        check("R1 idle outputs in reset", {rvalid, rdata}, 17'h0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].loc, VEC[i].wr, VEC[i].rd, VEC[i].wd, VEC[i].ex,
                   $sformatf("R%0d vector %0d", VEC[i].req, i));
        end

        // R9: back-to-back reads from 0x1FE and 0x1FF
        access(2'd0, 1'b1, 1'b0, 16'hFEFE, 16'h0, "R2");
        access(2'd1, 1'b1, 1'b0, 16'h0101, 16'h0, "R2");
        @(negedge clk);
        loc = 2'd2; rd_en = 1'b1;
        @(negedge clk);
        check("R9 first back-to-back", {rvalid, rdata}, {1'b1, 16'hC0DE});
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 second back-to-back", {rvalid, rdata}, {1'b1, 16'hBEEF});
        @(negedge clk);
        check("R9 response ends", {rvalid, rdata}, 17'h0);

        // R11: both strobes together act as a write
        access(2'd0, 1'b1, 1'b0, 16'h0000, 16'h0, "R2");
        access(2'd1, 1'b1, 1'b0, 16'h0000, 16'h0, "R2");
        @(negedge clk);
        loc = 2'd3; wr_en = 1'b1; rd_en = 1'b1; wdata = 16'h6666;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R11 no response", {16'h0, rvalid}, 17'h0);
        access(2'd0, 1'b0, 1'b1, 16'h0, 16'h0101, "R11 single bump");
        access(2'd0, 1'b1, 1'b0, 16'h0000, 16'h0, "R2");
        access(2'd3, 1'b0, 1'b1, 16'h0, 16'h6666, "R11 write landed");

        // R1: reset clears pointer and registers
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 outputs", {rvalid, rdata}, 17'h0);
        rst_n = 1'b1;
        access(2'd0, 1'b0, 1'b1, 16'h0, 16'h0000, "R1 ptr low");
        access(2'd1, 1'b0, 1'b1, 16'h0, 16'h0000, "R1 ptr high");
        for (int k = 0; k < 13; k++) begin
            access(2'd3, 1'b0, 1'b1, 16'h0, 16'h0000, $sformatf("R1 reg %0d", k));
        end
        summary();
    end

endmodule